// File: doc/BRIEF.md
# Quarter-Tap Data Phase Steering Controller

This controller sits in the sampled domain of a half-rate bang-bang clock and data recovery loop. It corrects frequency offset by shifting the data, not the clock. One of four data delay taps feeds the phase detector, and adjacent taps are a quarter unit interval apart. At every data transition the block receives the sign of the in-phase clock sample, the sign of the quadrature clock sample, and a strobe that marks the transition as valid. The two signs show whether the data edge has drifted more than a quarter interval late or early. No amplitude is needed for this. When the same verdict appears on two valid transitions in a row, the controller steps a one-hot tap pointer one position to lengthen or shorten a single unit interval. The pointer wraps at both ends, because data phases half a clock period apart look the same to a half-rate detector.

Once the loop is locked the verdicts stop. A run of valid transitions with no verdict therefore marks the controller as locked. From then on it freezes the tap and raises a bypass indication so that the delay path can be powered down. The edge strobe is a valid-only stream with no ready signal. The block accepts one sample on every cycle and never applies back-pressure, so the upstream sampler needs no stall path.

Top module: `dphase_steer`

## Requirements
- R1: `tap_sel` is 4 bits wide and always has exactly one bit set. Bit 0 is the least-delayed tap (0°) and bit 3 is the most-delayed tap (135°). A single update moves the set bit by exactly one position, cyclically.
- R2: On a cycle with `edge_vld`=1, the verdict is decoded from the signs, where 1 means a positive sample. `isamp_pos`=0 with `qsamp_pos`=1 is LATE. `isamp_pos`=0 with `qsamp_pos`=0 is EARLY. `isamp_pos`=1 is no verdict.
- R3: A LATE verdict on two consecutive valid transitions moves the set bit from bit k to bit k+1. The new value is visible right after the clock edge that samples the second transition.
- R4: An EARLY verdict on two consecutive valid transitions moves the set bit from bit k to bit k-1, with the same timing as R3.
- R5: Stepping toward more delay from bit 3 wraps the pointer to bit 0.
- R6: Stepping toward less delay from bit 0 wraps the pointer to bit 3.
- R7: Cycles with `edge_vld`=0 are ignored, whatever the signs are. A single verdict followed by a no-verdict transition or by the opposite verdict causes no step.
- R8: After every step the verdict history is cleared, so a third agreeing transition alone does not step again.
- R9: After LOCK_EDGES consecutive valid transitions with no verdict (default 256), `bypass_path` goes to 1 and `adjust_active` goes to 0. Both take effect after the edge that samples the last of those transitions. The tap is then held against any verdict. A verdict that arrives earlier restarts the count.
- R10: While `enable_i`=0, `adjust_active` is 0, the tap is held, and the verdict history, lock count and lock state are cleared.
- R11: A synchronous reset (`rst`=1) sets `tap_sel` to 4'b0001, `bypass_path` to 0 and the history to empty. With `enable_i`=1, `adjust_active` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Controller enable; 0 forces it off |
| edge_vld | input | 1 | Valid strobe for a data transition |
| isamp_pos | input | 1 | Sign of in-phase clock sample at the edge |
| qsamp_pos | input | 1 | Sign of quadrature clock sample at the edge |
| tap_sel | output | 4 | One-hot data delay tap select |
| adjust_active | output | 1 | Steering is enabled and not locked |
| bypass_path | output | 1 | Lock reached; delay path may be bypassed |

## Verification
The assertions assume that `isamp_pos` and `qsamp_pos` are only meaningful while `edge_vld` is high. They also assume that `rst` is held for at least one clock before the first unreset cycle, so the pointer starts from a known state. The stimulus changes signs freely on cycles where the strobe is low, to show those cycles are ignored. It holds reset for several cycles at the start, and it toggles `enable_i` only away from the clock edge. A reference model in the bench tracks the history, the pointer and the lock count from the requirement text alone.

// File: rtl/dphase_pkg.sv
package dphase_pkg;
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_LATE  = 2'd1,
    VERD_EARLY = 2'd2
  } verdict_t;
endpackage

// File: rtl/dphase_classify.sv
module dphase_classify
  import dphase_pkg::*;
(
  input  logic     edge_vld,
  input  logic     isamp_pos,
  input  logic     qsamp_pos,
  output verdict_t verdict
);
  // Data edge outside the +/- quarter-UI window is seen as a negative
  // in-phase sample; the quadrature sign tells which side it left by.
  always_comb begin
    verdict = VERD_NONE;
    if (edge_vld && !isamp_pos) begin
      verdict = qsamp_pos ? VERD_LATE : VERD_EARLY;
    end
  end
endmodule

// File: rtl/dphase_filter.sv
module dphase_filter
  import dphase_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     edge_vld,
  input  verdict_t verdict,
  output logic     step_fwd,
  output logic     step_bwd
);
  localparam int CW = $clog2(DEPTH + 1);

  verdict_t      last_q;
  logic [CW-1:0] run_q;
  logic          agree;
  logic          fire;

  always_comb begin
    agree    = edge_vld && (verdict != VERD_NONE) && (verdict == last_q);
    fire     = agree && (run_q == CW'(DEPTH - 1));
    step_fwd = !hold && fire && (verdict == VERD_LATE);
    step_bwd = !hold && fire && (verdict == VERD_EARLY);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      last_q <= VERD_NONE;
      run_q  <= '0;
    end else if (edge_vld) begin
      if (verdict == VERD_NONE || fire) begin
        last_q <= VERD_NONE;
        run_q  <= '0;
      end else if (agree) begin
        run_q <= run_q + 1'b1;
      end else begin
        last_q <= verdict;
        run_q  <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/dphase_pointer.sv
module dphase_pointer #(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_fwd,
  input  logic            step_bwd,
  output logic [TAPS-1:0] tap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap <= TAPS'(1);
    end else if (step_fwd) begin
      tap <= {tap[TAPS-2:0], tap[TAPS-1]};
    end else if (step_bwd) begin
      tap <= {tap[0], tap[TAPS-1:1]};
    end
  end
endmodule

// File: rtl/dphase_lockmon.sv
module dphase_lockmon
  import dphase_pkg::*;
#(
  parameter int LOCK_EDGES = 256
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     edge_vld,
  input  verdict_t verdict,
  output logic     locked
);
  localparam int CW = $clog2(LOCK_EDGES + 1);

  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      quiet_q <= '0;
      locked  <= 1'b0;
    end else if (!locked && edge_vld) begin
      if (verdict != VERD_NONE) begin
        quiet_q <= '0;
      end else if (quiet_q == CW'(LOCK_EDGES - 1)) begin
        locked <= 1'b1;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dphase_steer.sv
module dphase_steer
  import dphase_pkg::*;
#(
  parameter int TAPS       = 4,
  parameter int DEPTH      = 2,
  parameter int LOCK_EDGES = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable_i,
  input  logic            edge_vld,
  input  logic            isamp_pos,
  input  logic            qsamp_pos,
  output logic [TAPS-1:0] tap_sel,
  output logic            adjust_active,
  output logic            bypass_path
);
  verdict_t verdict;
  logic     locked;
  logic     hold;
  logic     step_fwd;
  logic     step_bwd;

  assign hold          = !enable_i || locked;
  assign adjust_active = enable_i && !locked;
  assign bypass_path   = locked;

  dphase_classify u_classify (
    .edge_vld (edge_vld),
    .isamp_pos(isamp_pos),
    .qsamp_pos(qsamp_pos),
    .verdict  (verdict)
  );

  dphase_filter #(.DEPTH(DEPTH)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .edge_vld(edge_vld),
    .verdict (verdict),
    .step_fwd(step_fwd),
    .step_bwd(step_bwd)
  );

  dphase_pointer #(.TAPS(TAPS)) u_pointer (
    .clk     (clk),
    .rst     (rst),
    .step_fwd(step_fwd),
    .step_bwd(step_bwd),
    .tap     (tap_sel)
  );

  dphase_lockmon #(.LOCK_EDGES(LOCK_EDGES)) u_lockmon (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable_i),
    .edge_vld(edge_vld),
    .verdict (verdict),
    .locked  (locked)
  );
endmodule

// File: rtl/dphase_steer_chk.sv
module dphase_steer_chk #(
  parameter int TAPS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            enable_i,
  input logic            edge_vld,
  input logic [TAPS-1:0] tap_sel,
  input logic            adjust_active,
  input logic            bypass_path
);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1);

  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tap_sel != $past(tap_sel)) |->
      (tap_sel == {$past(tap_sel[TAPS-2:0]), $past(tap_sel[TAPS-1])} ||
       tap_sel == {$past(tap_sel[0]), $past(tap_sel[TAPS-1:1])}));

  assert_novalid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !edge_vld) |=> $stable(tap_sel));

  assert_inactive_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !adjust_active) |=> $stable(tap_sel));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (bypass_path && enable_i) |=> (bypass_path || !enable_i));
endmodule

bind dphase_steer dphase_steer_chk #(.TAPS(TAPS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable_i     (enable_i),
  .edge_vld     (edge_vld),
  .tap_sel      (tap_sel),
  .adjust_active(adjust_active),
  .bypass_path  (bypass_path)
);

// File: tb/dphase_steer_test.sv
`timescale 1ns/1ps
module dphase_steer_test;
  localparam int LOCK = 256;

  typedef struct {
    logic [3:0] tap;
    logic       act;
    logic       byp;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable_i = 1'b1;
  logic       edge_vld = 1'b0;
  logic       isamp_pos = 1'b1;
  logic       qsamp_pos = 1'b0;
  logic [3:0] tap_sel;
  logic       adjust_active;
  logic       bypass_path;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // reference state, from the requirement text
  int m_idx = 0;
  int m_last = 0;
  int m_run = 0;
  int m_quiet = 0;
  bit m_lock = 0;

  always #2.5 clk = ~clk;

  dphase_steer uut (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (enable_i),
    .edge_vld     (edge_vld),
    .isamp_pos    (isamp_pos),
    .qsamp_pos    (qsamp_pos),
    .tap_sel      (tap_sel),
    .adjust_active(adjust_active),
    .bypass_path  (bypass_path)
  );

  task automatic push(input string tag);
    exp_t e;
    e.tap = 4'b0001 << m_idx;
    e.act = enable_i && !m_lock;
    e.byp = m_lock;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst = 1'b1; edge_vld = 1'b0; enable_i = 1'b1;
      m_idx = 0; m_last = 0; m_run = 0; m_quiet = 0; m_lock = 0;
      push("R11");
    end
  endtask

  // v: strobe; i,q: signs; en: enable
  task automatic drive(input logic v, input logic i, input logic qq,
                       input logic en, input string tag);
    int d;
    @(negedge clk);
    rst = 1'b0; edge_vld = v; isamp_pos = i; qsamp_pos = qq; enable_i = en;
    d = (i) ? 0 : (qq ? 1 : 2);   // R2: 1 late, 2 early, 0 none
    if (!en) begin
      m_last = 0; m_run = 0; m_quiet = 0; m_lock = 0;
    end else if (!m_lock && v) begin
      if (d == 0) begin
        m_last = 0; m_run = 0;
      end else if (d == m_last) begin
        m_run++;
        if (m_run == 2) begin
          m_idx = (d == 1) ? (m_idx + 1) % 4 : (m_idx + 3) % 4;
          m_last = 0; m_run = 0;
        end
      end else begin
        m_last = d; m_run = 1;
      end
      if (d != 0) m_quiet = 0;
      else if (m_quiet == LOCK - 1) m_lock = 1;
      else m_quiet++;
    end
    push(tag);
  endtask

  task automatic late(input string tag);  drive(1, 0, 1, 1, tag); endtask
  task automatic early(input string tag); drive(1, 0, 0, 1, tag); endtask
  task automatic quiet(input string tag); drive(1, 1, 0, 1, tag); endtask
  task automatic idle(input string tag);  drive(0, 0, 1, 1, tag); endtask

  // monitor: compare one expected item per clock, after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tap_sel !== e.tap || adjust_active !== e.act || bypass_path !== e.byp) begin
        errors++;
        $display("FAIL %s: tap=%b act=%b byp=%b expected tap=%b act=%b byp=%b",
                 e.tag, tap_sel, adjust_active, bypass_path, e.tap, e.act, e.byp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(3);                                   // R11
    late("R7"); quiet("R7");                       // isolated late dropped
    late("R7"); early("R7");                       // opposite breaks run
    late("R3"); late("R3");                        // step to bit1
    late("R8");                                    // history cleared, no step
    late("R3");                                    // second of new pair -> bit2
    late("R7"); idle("R7"); idle("R7"); late("R7"); // strobe-low cycles ignored -> bit3
    drive(1, 1, 1, 1, "R2"); drive(1, 1, 1, 1, "R2"); // in-phase positive: no verdict
    late("R5"); late("R5");                        // bit3 -> bit0 wrap
    early("R6"); early("R6");                      // bit0 -> bit3 wrap
    early("R4"); early("R4");                      // bit3 -> bit2
    drive(1, 0, 1, 0, "R10"); drive(1, 0, 1, 0, "R10"); // disabled: hold
    late("R10"); quiet("R10");                     // re-enabled, history was cleared
    for (int k = 0; k < 200; k++) quiet("R9");
    late("R9");                                    // restarts lock count
    for (int k = 0; k < 200; k++) quiet("R9");     // not yet locked
    for (int k = 0; k < 60; k++) quiet("R9");      // lock reached
    late("R9"); late("R9"); early("R9"); early("R9"); // held while locked
    drive(0, 1, 0, 0, "R10");                      // enable low clears lock
    late("R10"); late("R10");                      // steering again
    do_reset(2);                                   // R11 again
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending=%0d expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule